// File: doc/BRIEF.md
# Byte to 3-wire symbol transmitter and receiver

This block carries bytes over a three-wire differential link. A byte offered on a valid/ready port is converted into four base-6 digits. Each digit is sent as a 3-bit drive word, one per symbol cycle, on four consecutive cycles, with a strobe marking each symbol. The drive word feeds the three pairwise differential transmitters: bit 2 is X, bit 1 is Y and bit 0 is Z. The all-zero and all-one words are never driven, because neither puts a differential voltage on any receiver pair.

The receiving half takes strobed 3-bit words and maps each back to a digit. After four symbols it rebuilds the byte and presents it for one cycle with an error flag. The error flag is set when an illegal word arrives, or when the rebuilt value does not fit in a byte.

The base-6 digits are produced by an iterative converter. It takes one byte bit per cycle, most significant bit first, and runs through a chain of small radix-6 doubling cells, so the block has no combinational divider. The converter takes eight cycles. After that the four symbols go out, least significant digit first.

Top module: `mw3_link`

## Requirements
- R1: While `tx_strobe` is high, `tx_word` is never 3'b000 or 3'b111.
- R2: A digit value from 1 to 5 is driven unchanged as `tx_word` = {X,Y,Z}, so digit 3 gives 3'b011 and digit 5 gives 3'b101.
- R3: Digit value 0 is driven as `tx_word` = 3'b110.
- R4: An accepted byte B is sent as exactly four strobed symbols on four consecutive cycles. Symbol k (k = 0..3, with k = 0 first) carries digit floor(B / 6^k) mod 6.
- R5: `in_ready` is high only when the transmitter is idle. A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low from that edge until the fourth symbol has been sent, and it is low during every strobed symbol.
- R6: The receiver decodes 3'b110 as 0 and decodes 3'b001..3'b101 as their binary value. It accumulates digit k with weight 6^k. On the cycle after the fourth `rx_strobe`, it pulses `out_valid` for one cycle with `out_byte` equal to the low 8 bits of the sum.
- R7: If any of the four received words is 3'b000 or 3'b111, `out_err` is high on that byte's `out_valid` pulse, and the illegal word counts as digit 0. The flag does not carry over into the next byte.
- R8: If the rebuilt sum exceeds 255, `out_err` is high and `out_byte` holds the sum modulo 256.
- R9: After reset, `in_ready` is 1, `tx_strobe` is 0 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Transmitter idle, byte can be taken |
| in_byte | input | 8 | Byte to send |
| tx_word | output | 3 | Drive word {X,Y,Z} |
| tx_strobe | output | 1 | A symbol is on `tx_word` this cycle |
| rx_word | input | 3 | Received word {X,Y,Z} |
| rx_strobe | input | 1 | A symbol is on `rx_word` this cycle |
| out_valid | output | 1 | Rebuilt byte present (one cycle) |
| out_byte | output | 8 | Rebuilt byte |
| out_err | output | 1 | Illegal word or out-of-range value in this byte |

## Verification
The bench loops the drive word back into the receiver and sends every byte from 0 to 255. Each symbol is compared with a base-6 expansion that the bench computes itself, so digit order, the remapping of 0 to 110 and any carry slip in the converter each show up as a distinct mismatch. Hand-driven receive sequences follow. They contain 000 and 111 words, digit sets whose sum is above 255, and a clean byte straight after an errored one. These separate the illegal-word path, the range check and the clearing of the error flag.

// File: rtl/mw3_pkg.sv
// Shared constants, types and code-mapping helpers for the 3-wire link.
// Assumes a drive word of three bits {X,Y,Z}, one bit per wire pair.
package mw3_pkg;

    localparam int DIG_W  = 3;
    localparam int WORD_W = 3;
    localparam int RADIX  = 6;
    localparam logic [WORD_W-1:0] ZERO_WORD = 3'b110;
    localparam logic [WORD_W-1:0] IDLE_WORD = 3'b110;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_CONV = 2'd1,
        TX_SEND = 2'd2
    } tx_state_t;

    // Number of radix-6 digits needed to cover 2**w values.
    function automatic int num_digits(input int w);
        longint p;
        int n;
        p = 1;
        n = 0;
        while (p < (longint'(1) << w)) begin
            p = p * RADIX;
            n = n + 1;
        end
        return n;
    endfunction

    // RADIX raised to n.
    function automatic longint pow_radix(input int n);
        longint p;
        p = 1;
        for (int i = 0; i < n; i++) p = p * RADIX;
        return p;
    endfunction

    // Digit to drive word: 0 is moved onto the spare code 110.
    function automatic logic [WORD_W-1:0] enc_digit(input logic [DIG_W-1:0] d);
        return (d == '0) ? ZERO_WORD : d;
    endfunction

    // Drive word to digit; illegal words come back as 0.
    function automatic logic [DIG_W-1:0] dec_word(input logic [WORD_W-1:0] w);
        if (w == ZERO_WORD || w == 3'b000 || w == 3'b111) return '0;
        return w;
    endfunction

    // True for the two words with no differential voltage on any pair.
    function automatic logic word_illegal(input logic [WORD_W-1:0] w);
        return (w == 3'b000) || (w == 3'b111);
    endfunction

endpackage

// File: rtl/mw3_radix6_cell.sv
// One radix-6 digit of a doubling chain: d_out = (2*d_in + c_in) mod 6,
// c_out = carry into the next digit. Assumes d_in is 0..5.
module mw3_radix6_cell
    import mw3_pkg::*;
(
    input  logic [DIG_W-1:0] d_in,
    input  logic             c_in,
    output logic [DIG_W-1:0] d_out,
    output logic             c_out
);

    logic [DIG_W:0] twice;

    // Double the digit, add the incoming bit, fold back above 5.
    always_comb begin
        twice = {d_in, c_in};
        if (twice >= (DIG_W+1)'(RADIX)) begin
            d_out = DIG_W'(twice - (DIG_W+1)'(RADIX));
            c_out = 1'b1;
        end else begin
            d_out = twice[DIG_W-1:0];
            c_out = 1'b0;
        end
    end

endmodule

// File: rtl/mw3_tx.sv
// Transmit half: accepts a byte, converts it to NDIG radix-6 digits by
// shifting one bit per cycle (MSB first) through a chain of doubling cells,
// then issues the digits least significant first as drive words, one per
// cycle with tx_strobe high. Assumes NDIG digits are enough for DATA_W bits.
module mw3_tx
    import mw3_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NDIG   = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_byte,
    output logic [WORD_W-1:0] tx_word,
    output logic              tx_strobe
);

    localparam int BCW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int SIW = (NDIG > 1) ? $clog2(NDIG) : 1;

    tx_state_t                    state;
    logic [DATA_W-1:0]            shreg;
    logic [BCW-1:0]               bitcnt;
    logic [SIW-1:0]               sym_idx;
    logic [NDIG-1:0][DIG_W-1:0]   dig;
    logic [NDIG-1:0][DIG_W-1:0]   dig_nx;
    logic [NDIG:0]                carry;

    assign carry[0] = shreg[DATA_W-1];

    // Doubling chain: one cell per digit, carry ripples upward.
    genvar k;
    generate
        for (k = 0; k < NDIG; k++) begin : g_cell
            mw3_radix6_cell u_cell (
                .d_in  (dig[k]),
                .c_in  (carry[k]),
                .d_out (dig_nx[k]),
                .c_out (carry[k+1])
            );
        end
    endgenerate

    // Sequencer: idle -> convert DATA_W bits -> send NDIG symbols.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            shreg   <= '0;
            bitcnt  <= '0;
            sym_idx <= '0;
            dig     <= '0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (in_valid) begin
                        shreg  <= in_byte;
                        dig    <= '0;
                        bitcnt <= BCW'(DATA_W-1);
                        state  <= TX_CONV;
                    end
                end
                TX_CONV: begin
                    dig   <= dig_nx;
                    shreg <= shreg << 1;
                    if (bitcnt == '0) begin
                        sym_idx <= '0;
                        state   <= TX_SEND;
                    end else begin
                        bitcnt <= bitcnt - 1'b1;
                    end
                end
                TX_SEND: begin
                    if (sym_idx == SIW'(NDIG-1)) state <= TX_IDLE;
                    else sym_idx <= sym_idx + 1'b1;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // Line outputs: current digit encoded while sending, a legal filler otherwise.
    always_comb begin
        in_ready  = (state == TX_IDLE);
        tx_strobe = (state == TX_SEND);
        tx_word   = tx_strobe ? enc_digit(dig[sym_idx]) : IDLE_WORD;
    end

    // R1: no dead word ever goes onto the wires.
    a_r1_legal_word: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> (tx_word != 3'b000 && tx_word != 3'b111));

    // R4: the digit chain never overflows its top digit during conversion.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_CONV) |-> !carry[NDIG]);

    // R4: the burst ends after the last symbol.
    a_r4_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_strobe && sym_idx == SIW'(NDIG-1)) |=> !tx_strobe);

    // R5: acceptance drops ready on the next cycle.
    a_r5_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R5: ready stays low while symbols go out.
    a_r5_busy_while_send: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> !in_ready);

endmodule

// File: rtl/mw3_rx.sv
// Receive half: decodes strobed 3-bit words to radix-6 digits, accumulates
// them least significant first, and after NDIG symbols emits the byte with
// an error flag for illegal words or an out-of-range sum. Assumes symbols
// of one byte arrive in order; gaps between strobes are allowed.
module mw3_rx
    import mw3_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NDIG   = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              rx_strobe,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_byte,
    output logic              out_err
);

    localparam int SIW   = (NDIG > 1) ? $clog2(NDIG) : 1;
    localparam int ACC_W = $clog2(pow_radix(NDIG)) + 1;
    localparam logic [ACC_W-1:0] MAX_VAL = ACC_W'((longint'(1) << DATA_W) - 1);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] weight;
    logic [SIW-1:0]   idx;
    logic             bad;
    logic [ACC_W-1:0] acc_nx;
    logic             bad_nx;

    // Add the decoded digit at its weight; note illegal words.
    always_comb begin
        acc_nx = acc + ACC_W'(dec_word(rx_word)) * weight;
        bad_nx = bad | word_illegal(rx_word);
    end

    // Symbol counter, accumulator and byte output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            weight    <= ACC_W'(1);
            idx       <= '0;
            bad       <= 1'b0;
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (rx_strobe) begin
                if (idx == SIW'(NDIG-1)) begin
                    out_valid <= 1'b1;
                    out_byte  <= acc_nx[DATA_W-1:0];
                    out_err   <= bad_nx | (acc_nx > MAX_VAL);
                    acc       <= '0;
                    weight    <= ACC_W'(1);
                    idx       <= '0;
                    bad       <= 1'b0;
                end else begin
                    acc    <= acc_nx;
                    weight <= (weight << 2) + (weight << 1);
                    idx    <= idx + 1'b1;
                    bad    <= bad_nx;
                end
            end
        end
    end

    // R6: a byte needs several symbols, so pulses never touch.
    a_r6_valid_gap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R7: an illegal word mid-byte is remembered.
    a_r7_bad_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && word_illegal(rx_word) && idx != SIW'(NDIG-1)) |=> bad);

    // R7: a fresh byte starts with no error remembered.
    a_r7_bad_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !bad);

endmodule

// File: rtl/mw3_link.sv
// Top: byte-to-3-wire transmitter and 3-wire-to-byte receiver side by side.
// The two halves share only clock and reset; the line is looped externally.
module mw3_link
    import mw3_pkg::*;
#(
    parameter int DATA_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_byte,
    output logic [2:0]        tx_word,
    output logic              tx_strobe,
    input  logic [2:0]        rx_word,
    input  logic              rx_strobe,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_byte,
    output logic              out_err
);

    localparam int NDIG = num_digits(DATA_W);

    mw3_tx #(.DATA_W(DATA_W), .NDIG(NDIG)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_byte   (in_byte),
        .tx_word   (tx_word),
        .tx_strobe (tx_strobe)
    );

    mw3_rx #(.DATA_W(DATA_W), .NDIG(NDIG)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_word   (rx_word),
        .rx_strobe (rx_strobe),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .out_err   (out_err)
    );

endmodule

// File: tb/mw3_link_test.sv
module mw3_link_test;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       in_valid = 0;
    logic       in_ready;
    logic [7:0] in_byte = 0;
    logic [2:0] tx_word;
    logic       tx_strobe;
    logic [2:0] rx_word;
    logic       rx_strobe;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       out_err;

    logic       loop_en = 1;
    logic [2:0] drv_word = 3'b110;
    logic       drv_strobe = 0;

    int n_chk = 0;
    int n_fail = 0;
    int run = 0;

    typedef struct {
        logic [7:0] b;
        logic       e;
        string      tag;
    } exp_t;

    exp_t       out_q[$];
    logic [2:0] word_q[$];

    always #5 clk = ~clk;

    assign rx_word   = loop_en ? tx_word   : drv_word;
    assign rx_strobe = loop_en ? tx_strobe : drv_strobe;

    mw3_link uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
        .tx_word(tx_word), .tx_strobe(tx_strobe),
        .rx_word(rx_word), .rx_strobe(rx_strobe),
        .out_valid(out_valid), .out_byte(out_byte), .out_err(out_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic [2:0] word_of(input int d);
        return (d == 0) ? 3'b110 : 3'(d);
    endfunction

    // Driver: push expected words and result, then hand the byte over.
    task automatic send_byte(input int b);
        int v;
        exp_t x;
        v = b;
        for (int k = 0; k < 4; k++) begin
            word_q.push_back(word_of(v % 6));
            v = v / 6;
        end
        x.b = 8'(b); x.e = 1'b0; x.tag = "R6";
        out_q.push_back(x);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1; in_byte = 8'(b);
        @(negedge clk);
        in_valid = 0;
        chk(in_ready == 1'b0, "R5 ready low after accept", int'(in_ready), 0);
    endtask

    // Direct receive sequence with its expected result.
    task automatic rx_seq(input logic [2:0] w0, input logic [2:0] w1,
                          input logic [2:0] w2, input logic [2:0] w3,
                          input int b, input logic e, input string tag);
        exp_t x;
        logic [2:0] ws[4];
        x.b = 8'(b); x.e = e; x.tag = tag;
        out_q.push_back(x);
        ws[0] = w0; ws[1] = w1; ws[2] = w2; ws[3] = w3;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            drv_word = ws[k]; drv_strobe = 1;
        end
        @(negedge clk);
        drv_strobe = 0; drv_word = 3'b110;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare line words and rebuilt bytes against the queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_strobe) begin
                run++;
                chk(tx_word != 3'b000 && tx_word != 3'b111, "R1 legal word", int'(tx_word), 6);
                chk(!in_ready, "R5 ready low while sending", int'(in_ready), 0);
                if (word_q.size() == 0) begin
                    chk(0, "R4 unexpected symbol", int'(tx_word), -1);
                end else begin
                    logic [2:0] ew;
                    ew = word_q.pop_front();
                    if (ew == 3'b110)
                        chk(tx_word == ew, "R3 zero digit word", int'(tx_word), int'(ew));
                    else
                        chk(tx_word == ew, "R2 digit word (R4 order)", int'(tx_word), int'(ew));
                end
            end else if (run != 0) begin
                chk(run == 4, "R4 burst length", run, 4);
                run = 0;
            end
            if (out_valid) begin
                if (out_q.size() == 0) begin
                    chk(0, "R6 unexpected out_valid", int'(out_byte), -1);
                end else begin
                    exp_t x;
                    x = out_q.pop_front();
                    chk(out_byte == x.b, {x.tag, " out_byte"}, int'(out_byte), int'(x.b));
                    chk(out_err == x.e, {x.tag, " out_err"}, int'(out_err), int'(x.e));
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R9 reset in_ready", int'(in_ready), 1);
        chk(tx_strobe == 1'b0, "R9 reset tx_strobe", int'(tx_strobe), 0);
        chk(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);

        // R4 R6: every byte value through the loopback.
        for (int b = 0; b < 256; b++) send_byte(b);
        while (out_q.size() != 0 || word_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);

        loop_en = 0;
        // R6: all-zero digits direct.
        rx_seq(3'b110, 3'b110, 3'b110, 3'b110, 0, 1'b0, "R6 zero byte");
        // R8: 5*216 = 1080 -> 56 with error.
        rx_seq(3'b110, 3'b110, 3'b110, 3'b101, 56, 1'b1, "R8 overrange 1080");
        // R8: 5+30+180+216 = 431 -> 175 with error.
        rx_seq(3'b101, 3'b101, 3'b101, 3'b001, 175, 1'b1, "R8 overrange 431");
        // R7: 000 in second place counts as 0: 3+36+216 = 255, error.
        rx_seq(3'b011, 3'b000, 3'b001, 3'b001, 255, 1'b1, "R7 word 000");
        // R7: flag clears for the next clean byte, 255 exactly.
        rx_seq(3'b011, 3'b110, 3'b001, 3'b001, 255, 1'b0, "R7 cleared R8 edge 255");
        // R7: 111 in first place.
        rx_seq(3'b111, 3'b110, 3'b110, 3'b110, 0, 1'b1, "R7 word 111");
        // R6: 2+24+0+216 = 242 clean.
        rx_seq(3'b010, 3'b100, 3'b110, 3'b001, 242, 1'b0, "R6 mixed digits");
        repeat (4) @(negedge clk);
        chk(out_q.size() == 0, "R6 all results seen", out_q.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R5 watchdog: actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule